// File: doc/BRIEF.md
# Transient-Aware Victim Router

This block sits beside a first-level data cache and decides what happens to a line when the cache evicts it. Each line carries two metadata bits, a transient mark and a dirty mark, kept in a small register array. Requests from the load/store path update these bits. Evictions read them and pick one of three outcomes for the victim: hand it to the second-level cache for allocation, write it straight to main memory and skip the second level, or discard it.

Accesses with a streaming, use-once hint set the transient mark on the line they fill or touch. Ordinary accesses clear it. Stores set the dirty mark. A victim without the transient mark always goes to the second level, and carries its dirty status with it. A transient victim that was modified skips the second level and goes to memory. A transient victim that was never modified is discarded without any transaction.

The router holds one pending victim. Each output channel uses a valid/ready handshake. While the pending victim has not been accepted, the router stops taking new evictions.

Top module: `evict_router`

## Requirements
- R1: After reset every line's transient and dirty marks are clear, neither output channel is valid, and `evReady` is high. A line evicted with no request since reset therefore goes to the second-level channel with `l2Dirty` = 0.
- R2: A victim whose transient mark is clear and whose dirty mark is clear is offered on the second-level channel with `l2Dirty` = 0 and `l2Line` equal to the evicted line.
- R3: A victim whose transient mark is clear and whose dirty mark is set is offered on the second-level channel with `l2Dirty` = 1.
- R4: A victim whose transient mark and dirty mark are both set is offered on the memory channel with `memLine` equal to the evicted line. The second-level channel stays idle for it.
- R5: A victim whose transient mark is set and whose dirty mark is clear is discarded. Neither channel becomes valid, and `evReady` stays high.
- R6: On a request, `reqClass` codes 1, 2, 3 and 4 are transient: codes 1 and 2 are the two stream-touch hints, 3 is the least-recently-used-hinted vector load and 4 is the matching store. A transient code sets the line's transient mark. Codes 0, 6 and 7 clear it. A request with `reqWrite` = 1 sets the dirty mark. A request with `reqWrite` = 0 leaves the dirty mark unchanged.
- R7: `reqClass` code 5 invalidates the line. It clears both marks whatever `reqWrite` is.
- R8: While a victim is pending, `evReady` is low and any eviction offered is ignored. An output that is valid and not accepted holds its line and dirty values stable.
- R9: An accepted eviction clears both marks of that line. If a request targets the same line in the same cycle, the eviction is routed on the old marks, and the line then holds only the request's result: transient from the class, dirty equal to `reqWrite`.
- R10: An eviction accepted at a clock edge makes the chosen channel valid right after that edge. At most one channel is valid at a time. A channel drops valid right after the edge at which its ready was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqClass | input | 3 | Access class code (see R6, R7) |
| reqLine | input | LINE_W | Line the request fills or touches |
| reqWrite | input | 1 | Request writes the line |
| evValid | input | 1 | Eviction offered |
| evLine | input | LINE_W | Line being evicted |
| evReady | output | 1 | Router can take an eviction |
| l2Valid | output | 1 | Victim offered for second-level allocation |
| l2Ready | input | 1 | Second level accepts the victim |
| l2Line | output | LINE_W | Victim line index on the second-level channel |
| l2Dirty | output | 1 | Victim carries modified data |
| memValid | output | 1 | Victim offered for direct memory write-back |
| memReady | input | 1 | Memory accepts the write-back |
| memLine | output | LINE_W | Victim line index on the memory channel |

## Verification
The bench visits each of the four mark combinations. A router that ignored the dirty mark would send modified transient lines to the second level, and one that ignored the transient mark would never use the memory channel or drop anything. It checks that an ordinary access after a transient one clears the mark, and that invalidation clears a dirty line. It also re-evicts lines to show that eviction clears their marks. It stalls the output with ready held low and offers a second eviction meanwhile: a router that dropped its hold would lose or overwrite the pending victim. A request and an eviction to the same line in one cycle checks that routing uses the old marks and that the request's result survives the clear.

// File: rtl/evict_router_pkg.sv
package evict_router_pkg;

  // request class codes
  localparam logic [2:0] CLS_PLAIN       = 3'd0;
  localparam logic [2:0] CLS_TOUCH_T     = 3'd1;
  localparam logic [2:0] CLS_TOUCH_ST_T  = 3'd2;
  localparam logic [2:0] CLS_VLOAD_HINT  = 3'd3;
  localparam logic [2:0] CLS_VSTORE_HINT = 3'd4;
  localparam logic [2:0] CLS_INVAL       = 3'd5;

  typedef enum logic [1:0] {
    ROUTE_DROP = 2'd0,
    ROUTE_L2   = 2'd1,
    ROUTE_MEM  = 2'd2
  } route_t;

  // strobes from control to datapath
  typedef struct packed {
    logic applyReq;   // update marks of reqLine
    logic clearLine;  // eviction accepted: clear marks of evLine
    logic capture;    // latch victim into the pending register
  } ctrlStrobes_t;

  function automatic logic isTransientClass(input logic [2:0] cls);
    return (cls == CLS_TOUCH_T) || (cls == CLS_TOUCH_ST_T) ||
           (cls == CLS_VLOAD_HINT) || (cls == CLS_VSTORE_HINT);
  endfunction

endpackage

// File: rtl/evict_router_meta.sv
module evict_router_meta
  import evict_router_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [2:0]        reqClass,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqWrite,
  input  logic [LINE_W-1:0] evLine,
  output logic              victimTrans,
  output logic              victimDirty,
  output logic [LINE_W-1:0] pendLine,
  output logic              pendDirty
);

  logic [NUM_LINES-1:0] transFlag;
  logic [NUM_LINES-1:0] dirtyFlag;

  logic reqIsTrans;
  logic reqIsInval;

  always_comb begin
    reqIsTrans = isTransientClass(reqClass);
    reqIsInval = (reqClass == CLS_INVAL);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic reqHit;
    logic evHit;

    always_comb begin
      reqHit = strb.applyReq && (reqLine == LINE_W'(i));
      evHit  = strb.clearLine && (evLine == LINE_W'(i));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        transFlag[i] <= 1'b0;
        dirtyFlag[i] <= 1'b0;
      end else if (reqHit) begin
        if (reqIsInval) begin
          transFlag[i] <= 1'b0;
          dirtyFlag[i] <= 1'b0;
        end else begin
          transFlag[i] <= reqIsTrans;
          // a same-cycle eviction wipes the old dirty state first
          dirtyFlag[i] <= reqWrite | (dirtyFlag[i] & ~evHit);
        end
      end else if (evHit) begin
        transFlag[i] <= 1'b0;
        dirtyFlag[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    victimTrans = transFlag[evLine];
    victimDirty = dirtyFlag[evLine];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendLine  <= '0;
      pendDirty <= 1'b0;
    end else if (strb.capture) begin
      pendLine  <= evLine;
      pendDirty <= victimDirty;
    end
  end

endmodule

// File: rtl/evict_router_ctrl.sv
module evict_router_ctrl
  import evict_router_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         evValid,
  input  logic         victimTrans,
  input  logic         victimDirty,
  input  logic         l2Ready,
  input  logic         memReady,
  output ctrlStrobes_t strb,
  output logic         evReady,
  output logic         l2Valid,
  output logic         memValid
);

  logic   pendValid;
  logic   pendToMem;
  route_t route;
  logic   accept;
  logic   drained;

  always_comb begin
    if (!victimTrans)     route = ROUTE_L2;
    else if (victimDirty) route = ROUTE_MEM;
    else                  route = ROUTE_DROP;
  end

  always_comb begin
    evReady        = !pendValid;
    accept         = evValid && evReady;
    strb.applyReq  = reqValid;
    strb.clearLine = accept;
    strb.capture   = accept && (route != ROUTE_DROP);
    l2Valid        = pendValid && !pendToMem;
    memValid       = pendValid && pendToMem;
    drained        = (l2Valid && l2Ready) || (memValid && memReady);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendValid <= 1'b0;
      pendToMem <= 1'b0;
    end else if (strb.capture) begin
      pendValid <= 1'b1;
      pendToMem <= (route == ROUTE_MEM);
    end else if (drained) begin
      pendValid <= 1'b0;
    end
  end

endmodule

// File: rtl/evict_router.sv
module evict_router
  import evict_router_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [2:0]        reqClass,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqWrite,
  input  logic              evValid,
  input  logic [LINE_W-1:0] evLine,
  output logic              evReady,
  output logic              l2Valid,
  input  logic              l2Ready,
  output logic [LINE_W-1:0] l2Line,
  output logic              l2Dirty,
  output logic              memValid,
  input  logic              memReady,
  output logic [LINE_W-1:0] memLine
);

  ctrlStrobes_t      strb;
  logic              victimTrans;
  logic              victimDirty;
  logic [LINE_W-1:0] pendLine;
  logic              pendDirty;

  evict_router_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .evValid     (evValid),
    .victimTrans (victimTrans),
    .victimDirty (victimDirty),
    .l2Ready     (l2Ready),
    .memReady    (memReady),
    .strb        (strb),
    .evReady     (evReady),
    .l2Valid     (l2Valid),
    .memValid    (memValid)
  );

  evict_router_meta #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_meta (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .reqClass    (reqClass),
    .reqLine     (reqLine),
    .reqWrite    (reqWrite),
    .evLine      (evLine),
    .victimTrans (victimTrans),
    .victimDirty (victimDirty),
    .pendLine    (pendLine),
    .pendDirty   (pendDirty)
  );

  always_comb begin
    l2Line  = pendLine;
    l2Dirty = pendDirty;
    memLine = pendLine;
  end

endmodule

// File: rtl/evict_router_chk.sv
module evict_router_chk #(
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evReady,
  input logic              l2Valid,
  input logic              l2Ready,
  input logic [LINE_W-1:0] l2Line,
  input logic              l2Dirty,
  input logic              memValid,
  input logic              memReady,
  input logic [LINE_W-1:0] memLine
);

  p_one_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(l2Valid && memValid));

  p_block_while_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l2Valid || memValid) |-> !evReady);

  p_ready_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(l2Valid || memValid) |-> evReady);

  p_l2_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l2Valid && !l2Ready) |=> (l2Valid && $stable(l2Line) && $stable(l2Dirty)));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memLine)));

  p_l2_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (l2Valid && l2Ready) |=> !l2Valid);

  p_mem_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memReady) |=> !memValid);

endmodule

bind evict_router evict_router_chk #(.LINE_W(LINE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evReady  (evReady),
  .l2Valid  (l2Valid),
  .l2Ready  (l2Ready),
  .l2Line   (l2Line),
  .l2Dirty  (l2Dirty),
  .memValid (memValid),
  .memReady (memReady),
  .memLine  (memLine)
);

// File: tb/evict_router_test.sv
module evict_router_test;

  localparam int NL = 16;
  localparam int LW = 4;

  // vector fields: [20:17] req tag, [16:15] op, [14:12] class,
  // [11:8] line, [7] write, [6:5] expected route, [4] expected dirty
  localparam logic [1:0] OP_REQ = 2'd0, OP_EV = 2'd1;
  localparam logic [1:0] X_DROP = 2'd0, X_L2 = 2'd1, X_MEM = 2'd2;

  function automatic logic [20:0] mkV(input int tag, input logic [1:0] op,
      input logic [2:0] cls, input int line, input logic wr,
      input logic [1:0] exp, input logic expD);
    return {4'(tag), op, cls, 4'(line), wr, exp, expD, 4'd0};
  endfunction

  localparam int NV = 27;
  localparam logic [20:0] VEC [NV] = '{
    mkV(1, OP_EV,  3'd0, 3,  1'b0, X_L2,  1'b0),  // R1 untouched line
    mkV(2, OP_REQ, 3'd0, 4,  1'b0, X_DROP,1'b0),
    mkV(2, OP_EV,  3'd0, 4,  1'b0, X_L2,  1'b0),  // R2
    mkV(3, OP_REQ, 3'd0, 5,  1'b1, X_DROP,1'b0),
    mkV(3, OP_EV,  3'd0, 5,  1'b0, X_L2,  1'b1),  // R3
    mkV(4, OP_REQ, 3'd3, 6,  1'b0, X_DROP,1'b0),
    mkV(4, OP_REQ, 3'd4, 6,  1'b1, X_DROP,1'b0),
    mkV(4, OP_EV,  3'd0, 6,  1'b0, X_MEM, 1'b0),  // R4
    mkV(5, OP_REQ, 3'd1, 7,  1'b0, X_DROP,1'b0),
    mkV(5, OP_EV,  3'd0, 7,  1'b0, X_DROP,1'b0),  // R5
    mkV(6, OP_REQ, 3'd2, 8,  1'b1, X_DROP,1'b0),
    mkV(6, OP_EV,  3'd0, 8,  1'b0, X_MEM, 1'b0),  // R6 class 2
    mkV(6, OP_REQ, 3'd1, 9,  1'b0, X_DROP,1'b0),
    mkV(6, OP_REQ, 3'd0, 9,  1'b0, X_DROP,1'b0),
    mkV(6, OP_EV,  3'd0, 9,  1'b0, X_L2,  1'b0),  // R6 plain clears mark
    mkV(7, OP_REQ, 3'd0, 10, 1'b1, X_DROP,1'b0),
    mkV(7, OP_REQ, 3'd5, 10, 1'b1, X_DROP,1'b0),
    mkV(7, OP_EV,  3'd0, 10, 1'b0, X_L2,  1'b0),  // R7 invalidate
    mkV(9, OP_REQ, 3'd3, 11, 1'b1, X_DROP,1'b0),
    mkV(9, OP_EV,  3'd0, 11, 1'b0, X_MEM, 1'b0),
    mkV(9, OP_EV,  3'd0, 11, 1'b0, X_L2,  1'b0),  // R9 marks cleared
    mkV(6, OP_REQ, 3'd7, 12, 1'b0, X_DROP,1'b0),
    mkV(6, OP_EV,  3'd0, 12, 1'b0, X_L2,  1'b0),  // R6 class 7
    mkV(5, OP_REQ, 3'd4, 13, 1'b0, X_DROP,1'b0),
    mkV(5, OP_EV,  3'd0, 13, 1'b0, X_DROP,1'b0),  // R5 store hint, no write
    mkV(6, OP_REQ, 3'd6, 14, 1'b1, X_DROP,1'b0),
    mkV(6, OP_EV,  3'd0, 14, 1'b0, X_L2,  1'b1)   // R6 class 6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqClass = '0;
  logic [LW-1:0] reqLine = '0;
  logic reqWrite = 1'b0;
  logic evValid = 1'b0;
  logic [LW-1:0] evLine = '0;
  logic evReady, l2Valid, l2Dirty, memValid;
  logic l2Ready = 1'b0;
  logic memReady = 1'b0;
  logic [LW-1:0] l2Line, memLine;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evict_router #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqClass(reqClass), .reqLine(reqLine), .reqWrite(reqWrite),
    .evValid(evValid), .evLine(evLine), .evReady(evReady),
    .l2Valid(l2Valid), .l2Ready(l2Ready), .l2Line(l2Line), .l2Dirty(l2Dirty),
    .memValid(memValid), .memReady(memReady), .memLine(memLine)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] cls, input int line, input logic wr);
    @(negedge clk);
    reqValid = 1'b1; reqClass = cls; reqLine = LW'(line); reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // outputs change after the accepting edge; sampled at the next negedge
  task automatic doEvict(input int line, input logic [1:0] exp, input logic expD,
                         input string req);
    @(negedge clk);
    evValid = 1'b1; evLine = LW'(line);
    @(negedge clk);
    evValid = 1'b0;
    check({req, " l2Valid"},  int'(l2Valid),  int'(exp == X_L2));
    check({req, " memValid"}, int'(memValid), int'(exp == X_MEM));
    if (exp == X_L2) begin
      check({req, " l2Line"},  int'(l2Line),  line);
      check({req, " l2Dirty"}, int'(l2Dirty), int'(expD));
      check({req, " evReady low"}, int'(evReady), 0);
      l2Ready = 1'b1;
      @(negedge clk);
      l2Ready = 1'b0;
    end else if (exp == X_MEM) begin
      check({req, " memLine"}, int'(memLine), line);
      check({req, " evReady low"}, int'(evReady), 0);
      memReady = 1'b1;
      @(negedge clk);
      memReady = 1'b0;
    end
    check({req, " drained l2"},  int'(l2Valid),  0);
    check({req, " drained mem"}, int'(memValid), 0);
    check({req, " evReady"},     int'(evReady),  1);
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 evReady", int'(evReady), 1);
    check("R1 l2Valid", int'(l2Valid), 0);
    check("R1 memValid", int'(memValid), 0);

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[20:17], v);
      if (e[16:15] == OP_REQ) doReq(e[14:12], int'(e[11:8]), e[7]);
      else doEvict(int'(e[11:8]), e[6:5], e[4], tag);
    end

    // R8: stall with ready low, second eviction ignored
    doReq(3'd0, 2, 1'b1);
    @(negedge clk);
    evValid = 1'b1; evLine = 4'd2;
    @(negedge clk);
    evLine = 4'd0;  // keep offering another line while pending
    for (int k = 0; k < 3; k++) begin
      check("R8 held valid", int'(l2Valid), 1);
      check("R8 held line", int'(l2Line), 2);
      check("R8 held dirty", int'(l2Dirty), 1);
      check("R8 evReady low", int'(evReady), 0);
      @(negedge clk);
    end
    evValid = 1'b0;
    l2Ready = 1'b1;
    @(negedge clk);
    l2Ready = 1'b0;
    check("R8 drained", int'(l2Valid), 0);
    @(negedge clk);
    check("R8 ignored eviction not taken", int'(l2Valid | memValid), 0);

    // R9: same-cycle request and eviction on one line
    doReq(3'd3, 1, 1'b1);
    @(negedge clk);
    evValid = 1'b1; evLine = 4'd1;
    reqValid = 1'b1; reqClass = 3'd0; reqLine = 4'd1; reqWrite = 1'b1;
    @(negedge clk);
    evValid = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    check("R9 old marks route to mem", int'(memValid), 1);
    check("R9 mem line", int'(memLine), 1);
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    doEvict(1, X_L2, 1'b1, "R9 request result kept");

    // R1: mid-run reset clears marks
    doReq(3'd1, 15, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    doEvict(15, X_L2, 1'b0, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule